// File: doc/BRIEF.md
# Byte-Sequenced I2C Master

This block is a memory-mapped I2C master that moves exactly one byte per command. Software sees two byte-wide registers: a data register and a command/status register. Software loads the data register and then writes a command byte. The controller may first frame a START condition. It then clocks eight bits out of the data register, or into it, and handles the ninth (acknowledge) bit. It may finish with a STOP condition, and then drops its busy flag. SCL and SDA are open-drain: the block drives only output enables, and a 1 on an enable pulls the line low.

A register write to a slave takes three commands. The first sends the address byte with a START. The second sends the register index. The third sends the data byte with a STOP. Software polls busy between commands. A read sends the address with START and the read bit, then receives bytes. The last byte is received with NACK and STOP. The SCL period is a parameter counted in system clocks and is divided into four equal quarters.

Top module: `i2c_byte_master`

## Requirements
- R1: Offset 0 is the data register and offset 1 is the command/status register. A data byte written while idle reads back unchanged, and both registers read 0x00 after reset.
- R2: Writing the command register with bit 7 set while idle starts a transfer. Bit 7 reads 1 until the transfer ends. It reads 0 exactly Q*DIV_CLKS/4 clocks after the write edge, where Q counts 4 quarters for START, 36 quarters for the nine bit slots, and 4 quarters for STOP.
- R3: Command bit 0 = 0 transmits the data register MSB first. Command bit 0 = 1 receives a byte instead.
- R4: Command bit 1 = 1 makes SDA fall while SCL is high before the first bit. This works from an idle bus and from a bus held low after an earlier byte.
- R5: Command bit 2 = 1 makes SDA rise while SCL is high after the acknowledge slot, which leaves both lines released. Without bit 2, SCL stays held low and SDA is released when busy clears.
- R6: After a transmit, status bit 4 reads 1 if SDA was high in the acknowledge slot (NACK) and 0 if it was low. After a receive, it reads 0.
- R7: On a receive, command bit 5 = 1 releases SDA in the acknowledge slot (NACK). Command bit 5 = 0 pulls SDA low (ACK).
- R8: The received byte, assembled MSB first, is in the data register once busy reads 0.
- R9: Command bits 6 and 3 are stored and read back, and they do not change bus activity.
- R10: Writes to either register while busy are ignored.
- R11: Apart from START and STOP edges, SDA changes only while SCL is held low.
- R12: A command write with bit 7 clear stores the other command bits and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register offset: 0 data, 1 command/status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
Every result of a transfer is due at a single cycle: busy falls, and the status bit and the received byte become readable, exactly Q*DIV_CLKS/4 clocks after the launching write edge. The scoreboard records that edge, polls busy at each falling clock edge, and flags a mismatch in the cycle at which busy falls. Register readbacks, the slave's captured byte, the master's acknowledge level, the START/STOP counts and the SCL hold state are all sampled in that same falling-edge window. Writes made while busy are issued in the first cycles of the transfer, so their absence of effect shows in that final readback.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
   localparam int BYTE_W = 8;

   // command/status bit positions
   localparam int CB_DIR   = 0;
   localparam int CB_START = 1;
   localparam int CB_STOP  = 2;
   localparam int CB_FAIL  = 4;
   localparam int CB_NACK  = 5;
   localparam int CB_GO    = 7;

   // bits kept from a command write (go and fail are not stored)
   localparam logic [BYTE_W-1:0] CFG_MASK = 8'h6F;

   typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BIT, PH_STOP} phase_e;

   typedef struct packed {
      logic nack;
      logic stop;
      logic start;
      logic rx;
   } cmd_t;
endpackage

// File: rtl/i2c_bm_qtick.sv
module i2c_bm_qtick #(
   parameter int QTR = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int CW = (QTR > 2) ? $clog2(QTR) : 1;
   localparam logic [CW-1:0] LAST = CW'(QTR - 1);

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart || tick) cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '1;
            else        st_q <= {st_q[STAGES-2+((STAGES==1)?1:0):0], d} ;
         end
         assign q = st_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
   import i2c_bm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              launch,
   output cmd_t              cmd,
   output logic [BYTE_W-1:0] data_val,
   output logic              busy,
   input  logic              done,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              fail
);
   logic [BYTE_W-1:0] data_q;
   logic [BYTE_W-1:0] cfg_q;
   logic              busy_q;
   logic              fail_q;
   logic [BYTE_W-1:0] status;

   assign launch   = wr_en && addr && wdata[CB_GO] && !busy_q;
   assign cmd      = '{nack: wdata[CB_NACK], stop: wdata[CB_STOP],
                       start: wdata[CB_START], rx: wdata[CB_DIR]};
   assign data_val = data_q;
   assign busy     = busy_q;

   always_comb begin
      status          = cfg_q;
      status[CB_GO]   = busy_q;
      status[CB_FAIL] = fail_q;
   end

   assign rdata = addr ? status : data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         cfg_q  <= '0;
         busy_q <= 1'b0;
         fail_q <= 1'b0;
      end else if (done) begin
         busy_q <= 1'b0;
         fail_q <= fail;
         if (cfg_q[CB_DIR]) data_q <= rx_byte;
      end else if (wr_en && !busy_q) begin
         if (addr) begin
            cfg_q <= wdata & CFG_MASK;
            if (wdata[CB_GO]) begin
               busy_q <= 1'b1;
               fail_q <= 1'b0;
            end
         end else begin
            data_q <= wdata;
         end
      end
   end
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
   import i2c_bm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  cmd_t              cmd,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              tick,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              fail,
   output logic              framing
);
   localparam logic [3:0] ACK_SLOT  = 4'(BYTE_W);
   localparam logic [3:0] LAST_DATA = 4'(BYTE_W - 1);

   phase_e            phase_q;
   logic [1:0]        qtr_q;
   logic [3:0]        bit_q;
   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] sh_next;
   logic              rx_q, stop_q, nack_q;
   logic              scl_q, sda_q, fail_q;
   logic              ack_drive;

   assign sh_next   = rx_q ? sh_q : {sh_q[BYTE_W-2:0], 1'b0};
   assign ack_drive = rx_q & ~nack_q;

   assign done = tick && (qtr_q == 2'd3) &&
                 ((phase_q == PH_STOP) ||
                  (phase_q == PH_BIT && bit_q == ACK_SLOT && !stop_q));

   assign scl_oe  = scl_q;
   assign sda_oe  = sda_q;
   assign rx_byte = sh_q;
   assign fail    = fail_q;
   assign framing = (phase_q == PH_START) || (phase_q == PH_STOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         qtr_q   <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         rx_q    <= 1'b0;
         stop_q  <= 1'b0;
         nack_q  <= 1'b0;
         scl_q   <= 1'b0;
         sda_q   <= 1'b0;
         fail_q  <= 1'b0;
      end else if (launch) begin
         rx_q   <= cmd.rx;
         stop_q <= cmd.stop;
         nack_q <= cmd.nack;
         sh_q   <= tx_byte;
         fail_q <= 1'b0;
         qtr_q  <= '0;
         bit_q  <= '0;
         if (cmd.start) begin
            phase_q <= PH_START;
            sda_q   <= 1'b0;
         end else begin
            phase_q <= PH_BIT;
            scl_q   <= 1'b1;
            sda_q   <= cmd.rx ? 1'b0 : ~tx_byte[BYTE_W-1];
         end
      end else if (tick) begin
         qtr_q <= qtr_q + 2'd1;
         unique case (phase_q)
            PH_START: begin
               unique case (qtr_q)
                  2'd0: scl_q <= 1'b0;
                  2'd1: sda_q <= 1'b1;
                  2'd2: scl_q <= 1'b1;
                  default: begin
                     phase_q <= PH_BIT;
                     bit_q   <= '0;
                     sda_q   <= rx_q ? 1'b0 : ~sh_q[BYTE_W-1];
                  end
               endcase
            end
            PH_BIT: begin
               unique case (qtr_q)
                  2'd0: scl_q <= 1'b0;
                  2'd1: begin
                     if (bit_q != ACK_SLOT) begin
                        if (rx_q) sh_q <= {sh_q[BYTE_W-2:0], sda_in};
                     end else if (!rx_q) begin
                        fail_q <= sda_in;
                     end
                  end
                  2'd2: scl_q <= 1'b1;
                  default: begin
                     if (bit_q != ACK_SLOT) begin
                        bit_q <= bit_q + 4'd1;
                        sh_q  <= sh_next;
                        if (bit_q == LAST_DATA) sda_q <= ack_drive;
                        else                    sda_q <= rx_q ? 1'b0 : ~sh_next[BYTE_W-1];
                     end else if (stop_q) begin
                        phase_q <= PH_STOP;
                        sda_q   <= 1'b1;
                     end else begin
                        phase_q <= PH_IDLE;
                        sda_q   <= 1'b0;
                     end
                  end
               endcase
            end
            PH_STOP: begin
               unique case (qtr_q)
                  2'd0: scl_q <= 1'b0;
                  2'd1: sda_q <= 1'b0;
                  2'd2: ;
                  default: phase_q <= PH_IDLE;
               endcase
            end
            default: qtr_q <= '0;
         endcase
      end
   end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
   import i2c_bm_pkg::*;
#(
   parameter int DIV_CLKS  = 400,
   parameter int SDA_SYNC  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       sda_in
);
   localparam int QTR = DIV_CLKS / 4;

   generate
      if (DIV_CLKS < 8 || (DIV_CLKS % 4) != 0) begin : g_bad_div
         $error("DIV_CLKS must be a multiple of 4 and at least 8");
      end
      if (SDA_SYNC < 0 || SDA_SYNC > 4) begin : g_bad_sync
         $error("SDA_SYNC must be in 0..4");
      end
      if (BYTE_W != 8) begin : g_bad_width
         $error("register width must be 8");
      end
   endgenerate

   logic              launch, busy, done, tick, fail, framing, sda_s;
   cmd_t              cmd;
   logic [BYTE_W-1:0] data_val, rx_byte;

   i2c_bm_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .launch(launch), .cmd(cmd),
      .data_val(data_val), .busy(busy), .done(done), .rx_byte(rx_byte),
      .fail(fail)
   );

   i2c_bm_qtick #(.QTR(QTR)) u_qtick (
      .clk(clk), .rst_n(rst_n), .restart(launch), .tick(tick)
   );

   i2c_bm_sync #(.STAGES(SDA_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   i2c_bm_engine u_engine (
      .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(cmd),
      .tx_byte(data_val), .tick(tick), .sda_in(sda_s), .scl_oe(scl_oe),
      .sda_oe(sda_oe), .done(done), .rx_byte(rx_byte), .fail(fail),
      .framing(framing)
   );
endmodule

// File: rtl/i2c_bm_checker.sv
module i2c_bm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic       reg_addr,
   input logic [7:0] reg_wdata,
   input logic       busy,
   input logic       done,
   input logic [7:0] data_val,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic       framing
);
   p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr && reg_wdata[7] && !busy) |=> busy);

   p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   p_rise_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && reg_addr && reg_wdata[7]));

   p_data_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(data_val));

   p_idle_sda_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sda_oe);

   p_sda_lowscl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe) && !framing && !$past(framing)) |-> $stable(sda_oe));
endmodule

bind i2c_byte_master i2c_bm_checker u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .busy(busy), .done(done), .data_val(data_val),
   .scl_oe(scl_oe), .sda_oe(sda_oe), .framing(framing)
);

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
   localparam int DIV = 16;
   localparam int QT  = DIV / 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       scl_oe, sda_oe;
   logic       sl_drv = 1'b0;
   logic       scl_line, sda_line;

   assign scl_line = ~scl_oe;
   assign sda_line = ~(sda_oe | sl_drv);

   i2c_byte_master #(.DIV_CLKS(DIV), .SDA_SYNC(2)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
      .sda_oe(sda_oe), .sda_in(sda_line)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // bus event counters
   int starts = 0, stops = 0, hi_edges = 0;
   always @(negedge sda_line) if (scl_line === 1'b1) starts++;
   always @(posedge sda_line) if (scl_line === 1'b1) stops++;
   always @(sda_line) if (scl_line === 1'b1) hi_edges++;

   // slave model
   bit         sl_mode = 0;      // 0 slave receives, 1 slave sends
   logic [7:0] sl_byte = 8'h00;
   bit         sl_ack  = 1;
   bit         rearm   = 0;
   logic [7:0] cap = 8'h00;
   logic       mack = 1'b0;

   initial begin
      int   rcnt;
      logic ps, pd;
      bit   pr;
      rcnt = 9; ps = 1'b1; pd = 1'b1; pr = 0;
      forever begin
         @(scl_line or sda_line or rearm);
         if (rearm != pr) begin rcnt = 0; pr = rearm; end
         if (scl_line === 1'b1 && ps === 1'b0) begin
            if (rcnt < 8) cap = {cap[6:0], sda_line};
            else if (rcnt == 8) mack = sda_line;
            rcnt++;
         end
         if (sda_line === 1'b0 && pd === 1'b1 && scl_line === 1'b1 && ps === 1'b1) rcnt = 0;
         if (scl_line === 1'b0) begin
            if (rcnt < 8)       sl_drv = sl_mode ? ~sl_byte[7-rcnt] : 1'b0;
            else if (rcnt == 8) sl_drv = !sl_mode && sl_ack;
            else                sl_drv = 1'b0;
         end
         ps = scl_line; pd = sda_line;
      end
   end

   typedef struct {
      string      tag;
      int         c0;
      int         nq;
      logic [7:0] ctrl;
      logic [7:0] data;
      bit         chk_cap;
      logic [7:0] cap;
      bit         chk_mack;
      logic       mack;
      int         st0, sp0, he0, dst, dsp;
      logic       held;
   } exp_t;

   exp_t sb[$];

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // driver: load data, launch, optionally poke while busy, push expectation
   task automatic xfer(input string tag, input logic [7:0] cmd, input logic [7:0] data,
                       input bit mode, input logic [7:0] sbyte, input bit sack,
                       input bit poke, input int nq, input logic [7:0] ectrl,
                       input logic [7:0] edata, input bit ccap, input bit cmack,
                       input logic emack, input int dst, input int dsp, input logic held);
      exp_t e;
      wr(1'b0, data);
      sl_mode = mode; sl_byte = sbyte; sl_ack = sack;
      rearm = ~rearm;
      @(negedge clk);
      e.c0 = cyc + 1; e.st0 = starts; e.sp0 = stops; e.he0 = hi_edges;
      reg_addr = 1'b1; reg_wdata = cmd; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      if (poke) begin
         wr(1'b0, 8'hFF);
         wr(1'b1, 8'h0B);
      end
      reg_addr = 1'b1;
      e.tag = tag; e.nq = nq; e.ctrl = ectrl; e.data = edata;
      e.chk_cap = ccap; e.cap = data; e.chk_mack = cmack; e.mack = emack;
      e.dst = dst; e.dsp = dsp; e.held = held;
      sb.push_back(e);
      while (sb.size() != 0) @(negedge clk);
   endtask

   // monitor: wait for busy to fall, compare against the queued item
   initial begin
      exp_t e;
      logic [7:0] v;
      forever begin
         while (sb.size() == 0) @(negedge clk);
         e = sb[0];
         forever begin
            @(negedge clk);
            if (reg_rdata[7] === 1'b0) break;
         end
         chk({e.tag, " R2 busy clear cycle"}, cyc, e.c0 + e.nq * QT);
         chk({e.tag, " R6/R9 status readback"}, reg_rdata, e.ctrl);
         reg_addr = 1'b0; #1;
         v = reg_rdata;
         reg_addr = 1'b1;
         chk({e.tag, " R8/R10 data register"}, v, e.data);
         if (e.chk_cap)  chk({e.tag, " R3 slave captured byte"}, cap, e.cap);
         if (e.chk_mack) chk({e.tag, " R7 master ack level"}, mack, e.mack);
         chk({e.tag, " R4 start count"}, starts - e.st0, e.dst);
         chk({e.tag, " R5 stop count"}, stops - e.sp0, e.dsp);
         chk({e.tag, " R11 sda edges while scl high"}, hi_edges - e.he0, e.dst + e.dsp);
         chk({e.tag, " R5 scl held"}, scl_oe, e.held);
         void'(sb.pop_front());
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reg_addr = 1'b0; #1;
      chk("R1 data after reset", reg_rdata, 8'h00);
      reg_addr = 1'b1; #1;
      chk("R1 status after reset", reg_rdata, 8'h00);
      chk("R5 scl released after reset", scl_oe, 1'b0);
      chk("R5 sda released after reset", sda_oe, 1'b0);

      wr(1'b0, 8'hA5);
      reg_addr = 1'b0; #1;
      chk("R1 data readback", reg_rdata, 8'hA5);

      s0 = starts;
      wr(1'b1, 8'h48);
      reg_addr = 1'b1; #1;
      chk("R12/R9 stored command without go", reg_rdata, 8'h48);
      repeat (20) @(negedge clk);
      chk("R12 no bus activity scl", scl_oe, 1'b0);
      chk("R12 no bus activity sda", sda_oe, 1'b0);
      chk("R12 no start", starts - s0, 0);

      // address write from idle bus, slave acks
      xfer("T1 addr", 8'hC2, 8'hA0, 0, 8'h00, 1, 0, 40, 8'h42, 8'hA0, 1, 0, 1'b0, 1, 0, 1'b1);
      // index byte, writes while busy must be ignored
      xfer("T2 idx", 8'hC0, 8'h3C, 0, 8'h00, 1, 1, 36, 8'h40, 8'h3C, 1, 0, 1'b0, 0, 0, 1'b1);
      // data byte with stop, slave refuses
      xfer("T3 nack", 8'hC4, 8'h81, 0, 8'h00, 0, 0, 40, 8'h54, 8'h81, 1, 0, 1'b0, 0, 1, 1'b0);
      // read sequence: address, receive with ack, repeated start, receive last with nack+stop
      xfer("T4 raddr", 8'hC2, 8'hA1, 0, 8'h00, 1, 0, 40, 8'h42, 8'hA1, 1, 0, 1'b0, 1, 0, 1'b1);
      xfer("T5 rx ack", 8'hC1, 8'h00, 1, 8'h5A, 0, 0, 36, 8'h41, 8'h5A, 0, 1, 1'b0, 0, 0, 1'b1);
      xfer("T6 restart", 8'hC2, 8'hA1, 0, 8'h00, 1, 0, 40, 8'h42, 8'hA1, 1, 0, 1'b0, 1, 0, 1'b1);
      xfer("T7 rx last", 8'hE5, 8'h00, 1, 8'hC3, 0, 1, 40, 8'h65, 8'hC3, 0, 1, 1'b1, 0, 1, 1'b0);
      // single framed byte: start and stop together, spare bit 3 set
      xfer("T8 framed", 8'hCE, 8'h55, 0, 8'h00, 1, 0, 44, 8'h4E, 8'h55, 1, 0, 1'b0, 1, 1, 1'b0);

      repeat (10) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule